// File: doc/BRIEF.md
# Copy Authorization and Block Protection Unit

This unit sits between the command decoder of a serial-bus EEPROM and its array write port. When a copy-scratchpad command arrives, the unit takes three authorization bytes. It compares them with the live target address and the transfer status byte. It then checks the partial-byte flag, the bad-sequence flag and the copy protection of the target. If every check passes, it programs the array and sets the authorization-accepted flag. If any check fails, it refuses the copy. While programming, it walks the scratchpad from the start offset T[4:0] to the ending offset E and asserts the array write port for each byte. A self-timed wait follows the walk. The bus then reads completion or refusal through single-bit read slots.

The unit keeps shadow copies of the per-block protection bytes and the two lock bytes. It updates them by watching its own array writes, so a protection byte that gets programmed takes effect on the next copy. A combinational query port gives the protection class of any address. The unit applies the same classification to each byte it programs, which makes write-protected bytes keep their contents and makes bytes in a write-once block only able to clear bits.

Top module: `copy_auth_unit`

## Requirements
- R1: After reset, `aa` is 0, `copy_busy` is 0, `auth_ready` is 0, `rslot_bit` is 1, and every data address is classified open.
- R2: The `q_mode` output encodes the class of `q_addr` as 0 (open), 1 (write protected), 2 (write-once: bits may only go from 1 to 0) or 3 (read-only). A data address lies in block n = addr[11:8] for n < 10. Its class is 1 when byte 0A00h+n holds 55h, 2 when that byte holds AAh, and 0 for any other value.
- R3: The three authorization bytes must equal, in order, the low byte of `ta`, the high byte of `ta`, and the status byte {aa, 0, pf, e_ofs}. Any difference refuses the copy.
- R4: A copy is refused while `pf` is 1.
- R5: A `rd_mem_cmd` pulse sets a bad-sequence condition that refuses every copy until a `wr_addr_done` pulse clears it.
- R6: An accepted copy sets `aa` on the edge that takes the third byte. It then writes array addresses {ta[15:5], k} for k from ta[4:0] up to `e_ofs`, one per cycle, and writes no other address. `aa` clears on `wr_addr_done`.
- R7: After programming, `rslot_bit` gives 0, 1, 0, 1 … with each `rslot_req` pulse. After a refusal it stays 1. A `bus_reset` pulse returns it to idle.
- R8: A copy into a write-protected block is accepted but leaves the array bytes unchanged.
- R9: A copy into a write-once block stores the AND of the old array byte and the scratchpad byte.
- R10: When byte 0A1Eh holds 55h or AAh, copies into write-protected blocks are refused. Copies into write-once blocks are still accepted.
- R11: When byte 0A1Fh holds 55h or AAh, copies into 0A00h–0A1Fh are refused, and the user bytes 0A0Ah–0A1Dh are classified 1.
- R12: A protection or lock byte that holds 55h or AAh is classified 3 and keeps its value through later copies. Addresses 0A20h–0A3Fh are always class 3 and are never changed.
- R13: The authorization byte stream is valid/ready. `auth_ready` is high only while the unit collects the three bytes after `copy_cmd`, and it never depends on `auth_valid`. A byte transfers on a clock edge where both are high, and the sender holds the byte stable until then.
- R14: `copy_busy` stays high for the byte walk plus `PROG_CYCLES` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| copy_cmd | input | 1 | Pulse: copy command decoded, begin collecting bytes |
| bus_reset | input | 1 | Pulse: bus reset, leave collect/done/refused state |
| rd_mem_cmd | input | 1 | Pulse: a memory read command was decoded |
| wr_addr_done | input | 1 | Pulse: write-scratchpad received a full target address |
| ta | input | 16 | Current target address register |
| e_ofs | input | 5 | Ending offset from the status register |
| pf | input | 1 | Partial-byte / invalid scratchpad flag |
| auth_valid | input | 1 | Authorization byte valid |
| auth_ready | output | 1 | Unit accepts an authorization byte |
| auth_data | input | 8 | Authorization byte |
| aa | output | 1 | Authorization-accepted flag |
| copy_busy | output | 1 | Programming in progress |
| rslot_req | input | 1 | Pulse: the master issued a read slot |
| rslot_bit | output | 1 | Bit returned in the read slot |
| sp_idx | output | 5 | Scratchpad byte index being programmed |
| sp_data | input | 8 | Scratchpad byte at `sp_idx` |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 16 | Array byte address |
| arr_wdata | output | 8 | Array write data |
| arr_rdata | input | 8 | Current array byte at `arr_addr` |
| q_addr | input | 16 | Protection query address |
| q_mode | output | 2 | Protection class of `q_addr` |

## Verification
The embedded properties check on every cycle the local rules that hold at any moment:
- array writes occur only while busy;
- `aa` rises only on entry to programming;
- a memory read always leaves the bad-sequence condition set;
- a self-locked protection byte never changes;
- the refusal response is all ones, and the completion response alternates;
- the programming timer stays in range.

Only the directed scenarios can show the results that depend on data and history:
- which bytes land in the array;
- that the AND rule applies in write-once blocks;
- that a block lock spares write-once blocks;
- that programming a protection byte changes how later copies are handled.

// File: rtl/ca_pkg.sv
package ca_pkg;

  typedef enum logic [1:0] {
    PM_OPEN   = 2'd0,
    PM_WPROT  = 2'd1,
    PM_WONCE  = 2'd2,
    PM_RDONLY = 2'd3
  } pmode_t;

  localparam logic [7:0] CODE_PROTECT = 8'h55;
  localparam logic [7:0] CODE_WONCE   = 8'hAA;

  function automatic logic is_lock_code(input logic [7:0] v);
    return (v == CODE_PROTECT) || (v == CODE_WONCE);
  endfunction

endpackage

// File: rtl/ca_prot_shadow.sv
module ca_prot_shadow
  import ca_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int NUM_BLOCKS  = 10,
  parameter int BLOCK_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_we,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [7:0]        upd_data,
  input  logic [ADDR_W-1:0] qa_addr,
  output pmode_t            qa_mode,
  input  logic [ADDR_W-1:0] qb_addr,
  output pmode_t            qb_mode,
  input  logic [ADDR_W-1:0] tgt_addr,
  output logic              tgt_blocked
);

  localparam int BLK_SH = $clog2(BLOCK_BYTES);
  localparam int BI_W   = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;
  localparam logic [ADDR_W-1:0] REG_BASE  = ADDR_W'(NUM_BLOCKS * BLOCK_BYTES);
  localparam logic [ADDR_W-1:0] CTL_END   = REG_BASE + ADDR_W'(NUM_BLOCKS);
  localparam logic [ADDR_W-1:0] BLK_LK_A  = REG_BASE + ADDR_W'(30);
  localparam logic [ADDR_W-1:0] PAGE_LK_A = REG_BASE + ADDR_W'(31);
  localparam logic [ADDR_W-1:0] RO_BASE   = REG_BASE + ADDR_W'(32);
  localparam logic [ADDR_W-1:0] MAP_END   = REG_BASE + ADDR_W'(64);

  logic [7:0]            ctl_q [NUM_BLOCKS];
  logic [7:0]            blk_lock_q;
  logic [7:0]            page_lock_q;
  logic [NUM_BLOCKS-1:0] blk_wp, blk_wo, ctl_self;
  logic                  blk_lk, page_lk;

  assign blk_lk  = is_lock_code(blk_lock_q);
  assign page_lk = is_lock_code(page_lock_q);

  for (genvar n = 0; n < NUM_BLOCKS; n++) begin : g_blk
    localparam logic [ADDR_W-1:0] MY_A = REG_BASE + ADDR_W'(n);
    assign blk_wp[n]   = (ctl_q[n] == CODE_PROTECT);
    assign blk_wo[n]   = (ctl_q[n] == CODE_WONCE);
    assign ctl_self[n] = is_lock_code(ctl_q[n]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q[n] <= 8'h00;
      else if (upd_we && upd_addr == MY_A && !ctl_self[n]) ctl_q[n] <= upd_data;
    end

    p_ctl_selflock_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_self[n] |=> $stable(ctl_q[n]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_lock_q  <= 8'h00;
      page_lock_q <= 8'h00;
    end else if (upd_we) begin
      if (upd_addr == BLK_LK_A && !blk_lk)   blk_lock_q  <= upd_data;
      if (upd_addr == PAGE_LK_A && !page_lk) page_lock_q <= upd_data;
    end
  end

  p_page_lock_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    page_lk |=> $stable(page_lock_q));

  // Two identical classifiers: one for the external query, one for the write path.
  logic [ADDR_W-1:0] q_addr_v [2];
  pmode_t            q_mode_v [2];
  assign q_addr_v[0] = qa_addr;
  assign q_addr_v[1] = qb_addr;
  assign qa_mode     = q_mode_v[0];
  assign qb_mode     = q_mode_v[1];

  for (genvar q = 0; q < 2; q++) begin : g_cls
    logic [BI_W-1:0] bi, ci;
    assign bi = BI_W'(q_addr_v[q] >> BLK_SH);
    assign ci = BI_W'(q_addr_v[q] - REG_BASE);
    always_comb begin
      if (q_addr_v[q] < REG_BASE) begin
        if (blk_wp[bi])      q_mode_v[q] = PM_WPROT;
        else if (blk_wo[bi]) q_mode_v[q] = PM_WONCE;
        else                 q_mode_v[q] = PM_OPEN;
      end else if (q_addr_v[q] < CTL_END) begin
        if (ctl_self[ci])    q_mode_v[q] = PM_RDONLY;
        else if (page_lk)    q_mode_v[q] = PM_WPROT;
        else                 q_mode_v[q] = PM_OPEN;
      end else if (q_addr_v[q] < BLK_LK_A) begin
        q_mode_v[q] = page_lk ? PM_WPROT : PM_OPEN;
      end else if (q_addr_v[q] == BLK_LK_A) begin
        if (blk_lk)          q_mode_v[q] = PM_RDONLY;
        else if (page_lk)    q_mode_v[q] = PM_WPROT;
        else                 q_mode_v[q] = PM_OPEN;
      end else if (q_addr_v[q] == PAGE_LK_A) begin
        q_mode_v[q] = page_lk ? PM_RDONLY : PM_OPEN;
      end else begin
        q_mode_v[q] = PM_RDONLY;
      end
    end
  end

  // Copy-protection decision for a copy target.
  logic [BI_W-1:0] tbi;
  assign tbi = BI_W'(tgt_addr >> BLK_SH);
  always_comb begin
    if (tgt_addr < REG_BASE)     tgt_blocked = blk_wp[tbi] && blk_lk;
    else if (tgt_addr < RO_BASE) tgt_blocked = page_lk;
    else                         tgt_blocked = (tgt_addr >= MAP_END);
  end

endmodule

// File: rtl/ca_prog_seq.sv
module ca_prog_seq #(
  parameter int ADDR_W      = 16,
  parameter int OFS_W       = 5,
  parameter int PROG_CYCLES = 2_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [OFS_W-1:0]  end_ofs,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [OFS_W-1:0]  ofs,
  output logic              busy,
  output logic              done
);

  localparam int TW = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
  localparam logic [TW-1:0] TMR_LAST = TW'(PROG_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_WALK, S_WAIT} sst_t;

  sst_t                     st_q;
  logic [ADDR_W-OFS_W-1:0]  page_q;
  logic [OFS_W-1:0]         cur_q, end_q;
  logic [TW-1:0]            tmr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      page_q <= '0;
      cur_q  <= '0;
      end_q  <= '0;
      tmr_q  <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start) begin
          page_q <= start_addr[ADDR_W-1:OFS_W];
          cur_q  <= start_addr[OFS_W-1:0];
          end_q  <= end_ofs;
          st_q   <= S_WALK;
        end
        S_WALK: if (cur_q == end_q) begin
          st_q  <= S_WAIT;
          tmr_q <= '0;
        end else begin
          cur_q <= cur_q + 1'b1;
        end
        S_WAIT: if (tmr_q == TMR_LAST) st_q <= S_IDLE;
                else tmr_q <= tmr_q + 1'b1;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign we   = (st_q == S_WALK);
  assign addr = {page_q, cur_q};
  assign ofs  = cur_q;
  assign busy = (st_q != S_IDLE);
  assign done = (st_q == S_WAIT) && (tmr_q == TMR_LAST);

  p_tmr_bound_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT) |-> (tmr_q <= TMR_LAST));
  p_done_after_walk_r14: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |-> 1'b0);

endmodule

// File: rtl/ca_auth_ctrl.sv
module ca_auth_ctrl #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              copy_cmd,
  input  logic              bus_reset,
  input  logic              rd_mem_cmd,
  input  logic              wr_addr_done,
  input  logic [ADDR_W-1:0] ta,
  input  logic [OFS_W-1:0]  e_ofs,
  input  logic              pf,
  input  logic              tgt_blocked,
  input  logic              auth_valid,
  output logic              auth_ready,
  input  logic [7:0]        auth_data,
  input  logic              seq_done,
  output logic              seq_start,
  output logic              aa,
  output logic              busy,
  input  logic              rslot_req,
  output logic              rslot_bit
);

  typedef enum logic [2:0] {A_IDLE, A_COLLECT, A_PROG, A_DONE, A_REFUSE} ast_t;

  ast_t       st_q;
  logic [1:0] cnt_q;
  logic [7:0] b0_q, b1_q;
  logic       aa_q, bs_q, tgl_q;
  logic       take, last, grant;
  logic [7:0] status_byte;

  assign auth_ready  = (st_q == A_COLLECT);
  assign take        = auth_valid && auth_ready;
  assign last        = take && (cnt_q == 2'd2);
  assign status_byte = 8'({aa_q, 1'b0, pf, e_ofs});
  assign grant       = last && (b0_q == ta[7:0]) && (b1_q == 8'(ta >> 8))
                    && (auth_data == status_byte) && !pf && !bs_q && !tgt_blocked;
  assign seq_start   = grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= A_IDLE;
      cnt_q <= '0;
      b0_q  <= '0;
      b1_q  <= '0;
      tgl_q <= 1'b0;
    end else begin
      case (st_q)
        A_IDLE, A_DONE, A_REFUSE: begin
          if (copy_cmd) begin
            st_q  <= A_COLLECT;
            cnt_q <= '0;
          end else if (bus_reset) begin
            st_q <= A_IDLE;
          end else if (st_q == A_DONE && rslot_req) begin
            tgl_q <= ~tgl_q;
          end
        end
        A_COLLECT: begin
          if (bus_reset) st_q <= A_IDLE;
          else if (take) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == 2'd0) b0_q <= auth_data;
            if (cnt_q == 2'd1) b1_q <= auth_data;
            if (last) st_q <= grant ? A_PROG : A_REFUSE;
          end
        end
        A_PROG: if (seq_done) begin
          st_q  <= A_DONE;
          tgl_q <= 1'b0;
        end
        default: st_q <= A_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aa_q <= 1'b0;
      bs_q <= 1'b0;
    end else begin
      if (grant)             aa_q <= 1'b1;
      else if (wr_addr_done) aa_q <= 1'b0;
      if (rd_mem_cmd)        bs_q <= 1'b1;
      else if (wr_addr_done) bs_q <= 1'b0;
    end
  end

  assign aa        = aa_q;
  assign busy      = (st_q == A_PROG);
  assign rslot_bit = (st_q == A_DONE) ? tgl_q : 1'b1;

  p_bs_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mem_cmd |=> bs_q);
  p_aa_rise_prog_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aa_q) |-> (st_q == A_PROG));
  p_refuse_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == A_REFUSE) |-> rslot_bit);
  p_alternate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == A_DONE && rslot_req && !copy_cmd && !bus_reset)
      |=> (rslot_bit != $past(rslot_bit)));
  p_ready_collect_r13: assert property (@(posedge clk) disable iff (!rst_n)
    auth_ready |-> !busy);

endmodule

// File: rtl/copy_auth_unit.sv
module copy_auth_unit
  import ca_pkg::*;
#(
  parameter int NUM_BLOCKS      = 10,
  parameter int PAGES_PER_BLOCK = 8,
  parameter int PAGE_BYTES      = 32,
  parameter int ADDR_W          = 16,
  parameter int PROG_CYCLES     = 2_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              copy_cmd,
  input  logic              bus_reset,
  input  logic              rd_mem_cmd,
  input  logic              wr_addr_done,
  input  logic [ADDR_W-1:0] ta,
  input  logic [4:0]        e_ofs,
  input  logic              pf,
  input  logic              auth_valid,
  output logic              auth_ready,
  input  logic [7:0]        auth_data,
  output logic              aa,
  output logic              copy_busy,
  input  logic              rslot_req,
  output logic              rslot_bit,
  output logic [4:0]        sp_idx,
  input  logic [7:0]        sp_data,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata,
  input  logic [7:0]        arr_rdata,
  input  logic [ADDR_W-1:0] q_addr,
  output logic [1:0]        q_mode
);

  localparam int OFS_W       = $clog2(PAGE_BYTES);
  localparam int BLOCK_BYTES = PAGES_PER_BLOCK * PAGE_BYTES;

  logic   tgt_blocked, seq_start, seq_done, seq_busy;
  pmode_t qa_mode, wr_mode;

  ca_prot_shadow #(
    .ADDR_W(ADDR_W), .NUM_BLOCKS(NUM_BLOCKS), .BLOCK_BYTES(BLOCK_BYTES)
  ) shadow_i (
    .clk(clk), .rst_n(rst_n),
    .upd_we(arr_we), .upd_addr(arr_addr), .upd_data(arr_wdata),
    .qa_addr(q_addr), .qa_mode(qa_mode),
    .qb_addr(arr_addr), .qb_mode(wr_mode),
    .tgt_addr(ta), .tgt_blocked(tgt_blocked)
  );

  ca_auth_ctrl #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) auth_i (
    .clk(clk), .rst_n(rst_n),
    .copy_cmd(copy_cmd), .bus_reset(bus_reset),
    .rd_mem_cmd(rd_mem_cmd), .wr_addr_done(wr_addr_done),
    .ta(ta), .e_ofs(e_ofs), .pf(pf), .tgt_blocked(tgt_blocked),
    .auth_valid(auth_valid), .auth_ready(auth_ready), .auth_data(auth_data),
    .seq_done(seq_done), .seq_start(seq_start),
    .aa(aa), .busy(copy_busy),
    .rslot_req(rslot_req), .rslot_bit(rslot_bit)
  );

  ca_prog_seq #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .PROG_CYCLES(PROG_CYCLES)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .start(seq_start), .start_addr(ta), .end_ofs(e_ofs),
    .we(arr_we), .addr(arr_addr), .ofs(sp_idx),
    .busy(seq_busy), .done(seq_done)
  );

  always_comb begin
    case (wr_mode)
      PM_OPEN:  arr_wdata = sp_data;
      PM_WONCE: arr_wdata = arr_rdata & sp_data;
      default:  arr_wdata = arr_rdata;
    endcase
  end

  assign q_mode = qa_mode;

  p_we_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> copy_busy);
  p_busy_match_r14: assert property (@(posedge clk) disable iff (!rst_n)
    copy_busy == seq_busy);
  p_rdonly_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && wr_mode == PM_RDONLY) |-> (arr_wdata == arr_rdata));

endmodule

// File: tb/copy_auth_unit_tb_top.sv
module copy_auth_unit_tb_top;

  localparam int PROGC = 50;
  localparam int MEMSZ = 2624;

  logic clk = 1'b0, rst_n = 1'b0;
  logic copy_cmd = 0, bus_reset = 0, rd_mem_cmd = 0, wr_addr_done = 0;
  logic [15:0] ta = '0;
  logic [4:0]  e_ofs = '0;
  logic pf = 0, auth_valid = 0, rslot_req = 0;
  logic [7:0] auth_data = '0;
  logic auth_ready, aa, copy_busy, rslot_bit, arr_we;
  logic [4:0] sp_idx;
  logic [7:0] sp_data, arr_wdata, arr_rdata;
  logic [15:0] arr_addr, q_addr = '0;
  logic [1:0] q_mode;

  logic [7:0] mem [MEMSZ];
  logic [7:0] sp  [32];
  int total = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  assign sp_data   = sp[sp_idx];
  assign arr_rdata = (int'(arr_addr) < MEMSZ) ? mem[arr_addr] : 8'hFF;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (arr_we && int'(arr_addr) < MEMSZ) mem[arr_addr] <= arr_wdata;
  end

  copy_auth_unit #(.PROG_CYCLES(PROGC)) dut_i (
    .clk(clk), .rst_n(rst_n), .copy_cmd(copy_cmd), .bus_reset(bus_reset),
    .rd_mem_cmd(rd_mem_cmd), .wr_addr_done(wr_addr_done), .ta(ta), .e_ofs(e_ofs),
    .pf(pf), .auth_valid(auth_valid), .auth_ready(auth_ready), .auth_data(auth_data),
    .aa(aa), .copy_busy(copy_busy), .rslot_req(rslot_req), .rslot_bit(rslot_bit),
    .sp_idx(sp_idx), .sp_data(sp_data), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_rdata(arr_rdata), .q_addr(q_addr), .q_mode(q_mode)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    auth_valid = 1'b1; auth_data = b;
    while (!auth_ready) @(negedge clk);
    @(negedge clk);
    auth_valid = 1'b0;
  endtask

  task automatic mode_is(input logic [15:0] a, input int exp, input string tag);
    q_addr = a; #1;
    chk(int'(q_mode) == exp, tag, int'(q_mode), exp);
  endtask

  // Runs a full copy; corrupt flips the status byte; returns after the outcome settles.
  task automatic copy_run(input logic [15:0] t, input logic [4:0] e, input logic p,
                          input logic corrupt, input logic exp_ok, input string tag);
    int n;
    logic [7:0] es;
    ta = t; e_ofs = e; pf = p;
    es = {1'b0, 1'b0, p, e} ^ (corrupt ? 8'h01 : 8'h00);
    pulse(copy_cmd);
    send_byte(t[7:0]);
    send_byte(t[15:8]);
    send_byte(es);
    chk(copy_busy == exp_ok, {tag, " accept"}, copy_busy, exp_ok);
    chk(aa == exp_ok, {tag, " aa"}, aa, exp_ok);
    n = 0;
    while (copy_busy && n < 5000) begin n++; @(negedge clk); end
    if (exp_ok) chk(n >= PROGC + 1, "R14 busy length", n, PROGC + 1);
    if (exp_ok) begin
      for (int k = 0; k < 4; k++) begin
        chk(rslot_bit == k[0], "R7 alternating completion", rslot_bit, k[0]);
        pulse(rslot_req);
      end
    end else begin
      for (int k = 0; k < 3; k++) begin
        chk(rslot_bit == 1'b1, "R7 refusal ones", rslot_bit, 1);
        pulse(rslot_req);
      end
    end
    pulse(bus_reset);
  endtask

  task automatic write_byte(input logic [15:0] a, input logic [7:0] v, input logic exp_ok,
                            input string tag);
    sp[a[4:0]] = v;
    pulse(wr_addr_done);
    copy_run(a, a[4:0], 1'b0, 1'b0, exp_ok, tag);
  endtask

  task automatic t_reset;
    chk(aa == 0, "R1 aa", aa, 0);
    chk(copy_busy == 0, "R1 busy", copy_busy, 0);
    chk(auth_ready == 0, "R1 ready", auth_ready, 0);
    chk(rslot_bit == 1, "R1 rslot", rslot_bit, 1);
    mode_is(16'h0000, 0, "R1 mode");
    mode_is(16'h0950, 0, "R1 mode last block");
  endtask

  task automatic t_basic;
    for (int i = 0; i < 32; i++) sp[i] = 8'(8'h10 + i);
    pulse(wr_addr_done);
    copy_run(16'h0044, 5'd7, 1'b0, 1'b0, 1'b1, "R6 basic");
    for (int i = 4; i < 8; i++)
      chk(mem[16'h0040 + i] == 8'(8'h10 + i), "R6 data", mem[16'h0040 + i], 8'h10 + i);
    chk(mem[16'h0043] == 8'hFF, "R6 below range", mem[16'h0043], 8'hFF);
    chk(mem[16'h0048] == 8'hFF, "R6 above range", mem[16'h0048], 8'hFF);
    pulse(wr_addr_done);
    chk(aa == 0, "R6 aa cleared", aa, 0);
  endtask

  task automatic t_mismatch;
    sp[4] = 8'h99;
    pulse(wr_addr_done);
    copy_run(16'h0044, 5'd4, 1'b0, 1'b1, 1'b0, "R3 mismatch");
    chk(mem[16'h0044] == 8'h14, "R3 untouched", mem[16'h0044], 8'h14);
    chk(auth_ready == 0, "R13 ready idle", auth_ready, 0);
  endtask

  task automatic t_pf;
    pulse(wr_addr_done);
    copy_run(16'h0044, 5'd4, 1'b1, 1'b0, 1'b0, "R4 pf");
    chk(mem[16'h0044] == 8'h14, "R4 untouched", mem[16'h0044], 8'h14);
  endtask

  task automatic t_badseq;
    sp[4] = 8'h5A;
    pulse(wr_addr_done);
    pulse(rd_mem_cmd);
    copy_run(16'h0044, 5'd4, 1'b0, 1'b0, 1'b0, "R5 read between");
    chk(mem[16'h0044] == 8'h14, "R5 untouched", mem[16'h0044], 8'h14);
    pulse(wr_addr_done);
    copy_run(16'h0044, 5'd4, 1'b0, 1'b0, 1'b1, "R5 cleared");
    chk(mem[16'h0044] == 8'h5A, "R5 written", mem[16'h0044], 8'h5A);
  endtask

  task automatic t_wprot;
    write_byte(16'h0A01, 8'h55, 1'b1, "R2 set protect");
    mode_is(16'h0100, 1, "R2 block1 protected");
    mode_is(16'h0A01, 3, "R12 ctl self lock");
    write_byte(16'h0100, 8'h77, 1'b1, "R8 copy protected block");
    chk(mem[16'h0100] == 8'hFF, "R8 kept", mem[16'h0100], 8'hFF);
    write_byte(16'h0A03, 8'h12, 1'b1, "R2 other code");
    mode_is(16'h0300, 0, "R2 other code open");
  endtask

  task automatic t_wonce;
    write_byte(16'h0A02, 8'hAA, 1'b1, "R2 set write-once");
    mode_is(16'h0200, 2, "R2 block2 write-once");
    write_byte(16'h0200, 8'h0F, 1'b1, "R9 first");
    chk(mem[16'h0200] == 8'h0F, "R9 and1", mem[16'h0200], 8'h0F);
    write_byte(16'h0200, 8'hF3, 1'b1, "R9 second");
    chk(mem[16'h0200] == 8'h03, "R9 and2", mem[16'h0200], 8'h03);
  endtask

  task automatic t_blklock;
    write_byte(16'h0A1E, 8'hAA, 1'b1, "R10 set block lock");
    mode_is(16'h0A1E, 3, "R12 block lock self");
    write_byte(16'h0100, 8'h11, 1'b0, "R10 protected refused");
    write_byte(16'h0200, 8'h01, 1'b1, "R10 write-once allowed");
    chk(mem[16'h0200] == 8'h01, "R10 write-once data", mem[16'h0200], 8'h01);
  endtask

  task automatic t_selflock;
    write_byte(16'h0A01, 8'h00, 1'b1, "R12 rewrite locked");
    chk(mem[16'h0A01] == 8'h55, "R12 ctl kept", mem[16'h0A01], 8'h55);
    mode_is(16'h0100, 1, "R12 still protected");
    write_byte(16'h0A20, 8'h00, 1'b1, "R12 ro page");
    chk(mem[16'h0A20] == 8'hFF, "R12 ro kept", mem[16'h0A20], 8'hFF);
    mode_is(16'h0A30, 3, "R12 ro class");
  endtask

  task automatic t_pagelock;
    mode_is(16'h0A0A, 0, "R11 user open");
    write_byte(16'h0A1F, 8'h55, 1'b1, "R11 set page lock");
    mode_is(16'h0A0A, 1, "R11 user protected");
    write_byte(16'h0A0A, 8'h42, 1'b0, "R11 refused");
    chk(mem[16'h0A0A] == 8'hFF, "R11 user kept", mem[16'h0A0A], 8'hFF);
  endtask

  initial begin
    for (int i = 0; i < MEMSZ; i++) mem[i] = 8'hFF;
    for (int i = 0; i < 32; i++) sp[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_mismatch;
    t_pf;
    t_badseq;
    t_wprot;
    t_wonce;
    t_blklock;
    t_selflock;
    t_pagelock;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule